// File: doc/BRIEF.md
# Sixteen-Pin Banked GPIO Controller with Edge Interrupts

This block controls sixteen general-purpose pins through a byte-wide register bus. The pins form two banks of eight: pins 0 to 7 in bank 0 and pins 8 to 15 in bank 1. Every pin has two control bytes. The drive byte sets direction, output value, push-pull or open-drain drive, and the pull resistor. The sense byte selects edge detection and returns the synchronised input level. All of these settings appear at the block's edge as plain pad-control signals.

Each input pin passes through a two-stage synchroniser. An edge that matches the pin's detection mode latches a pending bit. Each bank has one status byte, which software acknowledges by writing 1s, and one mask byte. A single interrupt line is high while any pending bit is set and its mask bit is clear. Reads are combinational, and a write takes effect on the clock edge where `bus_wr` is high.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset every pin is an input with push-pull drive, no pull, output value 0 and detection disabled. Both mask bytes read 0xFF, both status bytes read 0x00, and `irq` is low.
- R2: The drive byte of pin p lives at 0x2B+p for p<8 and at 0x3B+(p-8) for p>=8. Bits 5:0 are writable and read back; bits 7:6 read 0.
- R3: Drive-byte fields and their pad outputs:
  - bit 0 is `pad_out`;
  - bit 5 is direction, 1 = output, and it asserts `pad_oe`;
  - bit 4 = 1 selects open-drain, where `pad_oe` is held low while bit 0 is 1;
  - bit 3 is `pull_en`;
  - bits 2:1 are `pull_sel[2p+1:2p]`, with 0 strong down, 1 strong up, 2 weak down, 3 weak up.
- R4: The sense byte of pin p lives at 0x33+p for p<8 and at 0x43+(p-8) for p>=8. Bits 2:1 hold the detection mode and read back. Bit 0 reads the pin level after two register stages. Bits 7:3 read 0.
- R5: Detection modes are 0 none, 1 falling, 2 rising, 3 both. A matching edge on `pin_in` sets the pin's pending bit at the third rising clock edge after the input changes, whether or not the pin is masked. A non-matching edge leaves the bit unchanged.
- R6: Status bytes sit at 0x0B (bank 0) and 0x0C (bank 1), with bit n for pin n of the bank. Writing a 1 clears a bit; writing a 0 leaves it unchanged.
- R7: When a new edge and a clearing write hit the same pending bit in the same cycle, the bit stays set.
- R8: Mask bytes sit at 0x19 (bank 0) and 0x1A (bank 1), read/write, and a 1 masks the pin. `irq` is high exactly while some pending bit is set with its mask bit clear, in the same cycle.
- R9: Reads from any other address return 0x00, and writes to them change no register or output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe, sampled on the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| pin_in | input | 16 | Asynchronous pin levels |
| pad_out | output | 16 | Per-pin output value |
| pad_oe | output | 16 | Per-pin driver enable |
| pull_en | output | 16 | Per-pin pull resistor enable |
| pull_sel | output | 32 | Two bits per pin selecting the pull |
| irq | output | 1 | Combined unmasked interrupt |

## Verification
The assertions assume three things about the inputs:
- `bus_wr` and `bus_addr` are stable around each rising edge;
- `pin_in` changes only between edges, so the synchroniser never sees a changing value;
- a clearing write's data is the only path that can drop a pending bit.

The stimulus drives every input on the falling clock edge, so each value holds for a full half period before it is sampled. The stimulus mixes these actions:
- walks and random values on the mapped addresses;
- writes to unmapped addresses;
- status writes timed to land on the cycle a new edge is detected;
- random toggling of `pin_in`.

Together they reach the edge-versus-clear and masked-pending cases.

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl #(
  parameter logic [7:0] DRV_BASE0  = 8'h2B,
  parameter logic [7:0] DRV_BASE1  = 8'h3B,
  parameter logic [7:0] SNS_BASE0  = 8'h33,
  parameter logic [7:0] SNS_BASE1  = 8'h43,
  parameter logic [7:0] STAT_ADDR0 = 8'h0B,
  parameter logic [7:0] STAT_ADDR1 = 8'h0C,
  parameter logic [7:0] MASK_ADDR0 = 8'h19,
  parameter logic [7:0] MASK_ADDR1 = 8'h1A
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  bus_addr,
  input  logic        bus_wr,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  input  logic [15:0] pin_in,
  output logic [15:0] pad_out,
  output logic [15:0] pad_oe,
  output logic [15:0] pull_en,
  output logic [31:0] pull_sel,
  output logic        irq
);
  localparam int BANK = 8;
  localparam int NPIN = 2 * BANK;

  function automatic logic [7:0] pin_addr(input int p, input logic [7:0] b0, input logic [7:0] b1);
    return (p < BANK) ? b0 + 8'(p) : b1 + 8'(p - BANK);
  endfunction

  logic [5:0]      drv   [NPIN];
  logic [1:0]      mode  [NPIN];
  logic [NPIN-1:0] sy1, sy2, sy3;
  logic [NPIN-1:0] pend, mask, det, clr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sy1 <= '0; sy2 <= '0; sy3 <= '0;
    end else begin
      sy1 <= pin_in; sy2 <= sy1; sy3 <= sy2;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int p = 0; p < NPIN; p++) begin
        drv[p]  <= '0;
        mode[p] <= '0;
      end
    end else if (bus_wr) begin
      for (int p = 0; p < NPIN; p++) begin
        if (bus_addr == pin_addr(p, DRV_BASE0, DRV_BASE1)) drv[p]  <= bus_wdata[5:0];
        if (bus_addr == pin_addr(p, SNS_BASE0, SNS_BASE1)) mode[p] <= bus_wdata[2:1];
      end
    end

  always_comb
    for (int p = 0; p < NPIN; p++)
      det[p] = (mode[p][1] & sy2[p] & ~sy3[p]) | (mode[p][0] & ~sy2[p] & sy3[p]);

  assign clr[BANK-1:0]    = (bus_wr && bus_addr == STAT_ADDR0) ? bus_wdata : '0;
  assign clr[NPIN-1:BANK] = (bus_wr && bus_addr == STAT_ADDR1) ? bus_wdata : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pend <= '0;
      mask <= '1;
    end else begin
      pend <= (pend & ~clr) | det;
      if (bus_wr && bus_addr == MASK_ADDR0) mask[BANK-1:0]    <= bus_wdata;
      if (bus_wr && bus_addr == MASK_ADDR1) mask[NPIN-1:BANK] <= bus_wdata;
    end

  always_comb begin
    bus_rdata = '0;
    for (int p = 0; p < NPIN; p++) begin
      if (bus_addr == pin_addr(p, DRV_BASE0, DRV_BASE1)) bus_rdata = {2'b00, drv[p]};
      if (bus_addr == pin_addr(p, SNS_BASE0, SNS_BASE1)) bus_rdata = {5'b0, mode[p], sy2[p]};
    end
    if (bus_addr == STAT_ADDR0) bus_rdata = pend[BANK-1:0];
    if (bus_addr == STAT_ADDR1) bus_rdata = pend[NPIN-1:BANK];
    if (bus_addr == MASK_ADDR0) bus_rdata = mask[BANK-1:0];
    if (bus_addr == MASK_ADDR1) bus_rdata = mask[NPIN-1:BANK];
  end

  always_comb
    for (int p = 0; p < NPIN; p++) begin
      pad_out[p]        = drv[p][0];
      pad_oe[p]         = drv[p][5] & ~(drv[p][4] & drv[p][0]);
      pull_en[p]        = drv[p][3];
      pull_sel[2*p +: 2] = drv[p][2:1];
    end

  assign irq = |(pend & ~mask);

  a_r8_all_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask) |-> !irq);

  for (genvar g = 0; g < NPIN; g++) begin : g_chk
    localparam logic [7:0] DA = (g < BANK) ? DRV_BASE0 + 8'(g) : DRV_BASE1 + 8'(g - BANK);
    localparam logic [7:0] SA = (g < BANK) ? STAT_ADDR0 : STAT_ADDR1;
    localparam int         BI = g % BANK;

    a_r3_oe_after_write: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == DA) |=>
        pad_oe[g] == ($past(bus_wdata[5]) & ~($past(bus_wdata[4]) & $past(bus_wdata[0]))));

    a_r5_disabled_no_pend: assert property (@(posedge clk) disable iff (!rst_n)
      (mode[g] == 2'd0 && !pend[g]) |=> !pend[g]);

    a_r7_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
      det[g] |=> pend[g]);

    a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == SA && bus_wdata[BI] && !det[g]) |=> !pend[g]);
  end
endmodule

// File: tb/gpio_bank_ctrl_tb.sv
`timescale 1ns/1ps
module gpio_bank_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [15:0] pin_in = '0;
  logic [15:0] pad_out, pad_oe, pull_en;
  logic [31:0] pull_sel;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  gpio_bank_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pull_en(pull_en),
    .pull_sel(pull_sel), .irq(irq)
  );

  int        m_drv  [16];
  int        m_mode [16];
  bit [15:0] m_pend, m_mask, hist1, hist2, hist3;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int drv_idx(input int a);
    if (a >= 'h2B && a <= 'h32) return a - 'h2B;
    if (a >= 'h3B && a <= 'h42) return a - 'h3B + 8;
    return -1;
  endfunction

  function automatic int sns_idx(input int a);
    if (a >= 'h33 && a <= 'h3A) return a - 'h33;
    if (a >= 'h43 && a <= 'h4A) return a - 'h43 + 8;
    return -1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < 16; p++) begin m_drv[p] = 0; m_mode[p] = 0; end
      m_pend = '0; m_mask = '1; hist1 = '0; hist2 = '0; hist3 = '0;
    end else begin
      bit [15:0] nd, cl;
      int a;
      nd = '0; cl = '0; a = int'(bus_addr);
      for (int p = 0; p < 16; p++) begin
        if (hist2[p] && !hist3[p] && (m_mode[p] == 2 || m_mode[p] == 3)) nd[p] = 1;
        if (!hist2[p] && hist3[p] && (m_mode[p] == 1 || m_mode[p] == 3)) nd[p] = 1;
      end
      if (bus_wr && a == 'h0B) cl[7:0]  = bus_wdata;
      if (bus_wr && a == 'h0C) cl[15:8] = bus_wdata;
      m_pend = (m_pend & ~cl) | nd;
      if (bus_wr) begin
        if (drv_idx(a) >= 0) m_drv[drv_idx(a)] = int'(bus_wdata[5:0]);
        if (sns_idx(a) >= 0) m_mode[sns_idx(a)] = int'(bus_wdata[2:1]);
        if (a == 'h19) m_mask[7:0]  = bus_wdata;
        if (a == 'h1A) m_mask[15:8] = bus_wdata;
      end
      hist3 = hist2; hist2 = hist1; hist1 = pin_in;
    end
  end

  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      int a;
      string tag;
      logic [7:0] er;
      logic [15:0] eo, eoe, epe;
      logic [31:0] eps;
      a = int'(bus_addr); er = '0; tag = "R9 unmapped read";
      if (drv_idx(a) >= 0) begin er = 8'(m_drv[drv_idx(a)]); tag = "R2 drive byte"; end
      if (sns_idx(a) >= 0) begin
        er = 8'((m_mode[sns_idx(a)] << 1) | int'(hist2[sns_idx(a)])); tag = "R4 sense byte";
      end
      if (a == 'h0B) begin er = m_pend[7:0];  tag = "R6 status0"; end
      if (a == 'h0C) begin er = m_pend[15:8]; tag = "R6 status1"; end
      if (a == 'h19) begin er = m_mask[7:0];  tag = "R8 mask0"; end
      if (a == 'h1A) begin er = m_mask[15:8]; tag = "R8 mask1"; end
      chk(tag, 32'(bus_rdata), 32'(er));
      for (int p = 0; p < 16; p++) begin
        bit dir, od, v;
        v = m_drv[p][0]; od = m_drv[p][4]; dir = m_drv[p][5];
        eo[p]  = v;
        eoe[p] = dir && !(od && v);
        epe[p] = m_drv[p][3];
        eps[2*p +: 2] = 2'(m_drv[p] >> 1);
      end
      chk("R3 pad_out", 32'(pad_out), 32'(eo));
      chk("R3 pad_oe", 32'(pad_oe), 32'(eoe));
      chk("R3 pull_en", 32'(pull_en), 32'(epe));
      chk("R3 pull_sel", pull_sel, eps);
      chk("R8 irq", 32'(irq), 32'(|(m_pend & ~m_mask)));
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [7:0] exp);
    bus_addr = a; #0.1;
    chk(tag, 32'(bus_rdata), 32'(exp));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd_chk("R1 mask0 reset", 8'h19, 8'hFF);
    rd_chk("R1 mask1 reset", 8'h1A, 8'hFF);
    rd_chk("R1 status1 reset", 8'h0C, 8'h00);
    rd_chk("R1 drive pin9 reset", 8'h3C, 8'h00);
    chk("R1 irq reset", 32'(irq), 0);
    chk("R1 pad_oe reset", 32'(pad_oe), 0);

    // R2 R3 drive walk
    for (int p = 0; p < 16; p++)
      wr((p < 8) ? 8'(8'h2B + p) : 8'(8'h3B + p - 8), 8'(8'hC0 | (p * 7 + 3)));
    @(negedge clk);
    rd_chk("R2 drive pin0 readback", 8'h2B, 8'h03);
    wr(8'h2C, 8'h31);  // open-drain, output, value 1
    @(negedge clk);
    chk("R3 open-drain released", 32'(pad_oe[1]), 0);
    wr(8'h2C, 8'h30);
    @(negedge clk);
    chk("R3 open-drain driving low", 32'(pad_oe[1]), 1);

    // R9 unmapped writes
    wr(8'h00, 8'hFF); wr(8'h4B, 8'hFF); wr(8'h1B, 8'h00);
    rd_chk("R9 unmapped 0x4B", 8'h4B, 8'h00);
    rd_chk("R9 mask0 untouched", 8'h19, 8'hFF);

    // R5 rising edge latency, masked and unmasked
    wr(8'h36, 8'h04);          // pin 3 rising
    wr(8'h37, 8'h02);          // pin 4 falling
    @(negedge clk); pin_in[3] = 1'b1; pin_in[4] = 1'b1;
    bus_addr = 8'h0B;
    repeat (2) @(negedge clk);
    rd_chk("R5 not yet pending", 8'h0B, 8'h00);
    @(negedge clk);
    rd_chk("R5 rising sets pin3 only", 8'h0B, 8'h08);
    chk("R5 masked pending no irq", 32'(irq), 0);
    wr(8'h19, 8'hF7);
    @(negedge clk);
    chk("R8 unmasked irq", 32'(irq), 1);
    wr(8'h0B, 8'h08);
    rd_chk("R6 ack clears", 8'h0B, 8'h00);

    // R7 edge beats clear
    wr(8'h38, 8'h06);          // pin 5 both
    @(negedge clk); pin_in[5] = 1'b1;
    @(negedge clk);
    @(negedge clk); bus_addr = 8'h0B; bus_wdata = 8'hFF; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
    rd_chk("R7 edge wins over clear", 8'h0B, 8'h20);
    wr(8'h0B, 8'h20);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      int sel;
      @(negedge clk);
      sel = $urandom_range(0, 9);
      case (sel)
        0: bus_addr = 8'h0B;
        1: bus_addr = 8'h0C;
        2: bus_addr = 8'h19;
        3: bus_addr = 8'h1A;
        4: bus_addr = 8'(8'h2B + $urandom_range(0, 7));
        5: bus_addr = 8'(8'h3B + $urandom_range(0, 7));
        6: bus_addr = 8'(8'h33 + $urandom_range(0, 7));
        7: bus_addr = 8'(8'h43 + $urandom_range(0, 7));
        default: bus_addr = 8'($urandom);
      endcase
      bus_wdata = 8'($urandom);
      bus_wr = ($urandom_range(0, 3) == 0);
      if ($urandom_range(0, 1) == 0) pin_in[$urandom_range(0, 15)] ^= 1'b1;
    end
    @(negedge clk); bus_wr = 1'b0;
    @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule